// File: doc/BRIEF.md
# Lockable Subsystem Identification Registers

The block keeps two 16-bit identification words, a subsystem vendor word and a subsystem device word. Both sit in one dword of a configuration space: the vendor word in the low half at byte offset 40h and the device word in the high half at 42h. Configuration software can rewrite them only while a lock bit is clear. The lock bit is bit 5 of a control dword at byte offset 80h. It comes out of reset set, so the words start out read-only.

A serial EEPROM controller can preload both words after reset. A strap input says whether an EEPROM is fitted. While one is fitted and its controller has not yet signalled completion, every configuration write is refused with a retry response. Preload strobes write the words whatever the state of the lock bit. The words, the lock bit and the preload state are cleared only by the global reset, so only that reset restarts a preload.

The configuration port works on dword addresses and answers in the same cycle. Reads return data and writes return a retry flag. A write that is not retried takes effect at the next clock edge.

Top module: `subsys_id_regs`

## Requirements
- R1: After the global reset both words read 0000h, the lock bit reads 1 and a read of dword 10h (byte 40h) returns 0000_0000h.
- R2: A read of dword 10h returns the device word in bits 31:16 and the vendor word in bits 15:0. A read of dword 20h (byte 80h) returns the lock bit in bit 5 and zeros in every other bit. A read of any other dword returns zero.
- R3: When the lock bit is 0 and writes are allowed, a write to dword 10h updates only the bytes whose byte enables are set. Enable bits 0 and 1 cover the vendor word and enable bits 2 and 3 cover the device word. With all four set, both words change in the same edge.
- R4: When the lock bit is 1, a write to dword 10h leaves both words unchanged.
- R5: A write to dword 20h with byte enable 0 set loads the lock bit from write-data bit 5 at the next edge. Without byte enable 0 the lock bit is unchanged.
- R6: With an EEPROM fitted and preload not yet done, a preload strobe loads the vendor and device words at the next edge, even when the lock bit is 1.
- R7: With an EEPROM fitted and preload not yet done, every configuration write asserts the retry output in the same cycle and changes neither the words nor the lock bit. Reads are still answered.
- R8: Once preload is done, further preload strobes are ignored. Done stays set until the global reset.
- R9: With no EEPROM fitted, preload counts as done from reset. Writes are never retried and preload strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global reset, active low, asynchronous |
| eeprom_en_i | input | 1 | Strap: an EEPROM is fitted and will preload |
| cfg_req_i | input | 1 | Configuration access valid |
| cfg_we_i | input | 1 | 1 for a write, 0 for a read |
| cfg_addr_i | input | 6 | Dword address (byte address bits 7:2) |
| cfg_be_i | input | 4 | Byte enables for writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, valid in the request cycle |
| cfg_retry_o | output | 1 | Write refused, must be repeated |
| pre_valid_i | input | 1 | Preload strobe for both words |
| pre_vendor_i | input | 16 | Preloaded vendor word |
| pre_device_i | input | 16 | Preloaded device word |
| pre_done_i | input | 1 | EEPROM controller has finished |
| pre_done_o | output | 1 | Preload phase complete |

## Verification
Several rules are checked on every cycle. A locked or retried write leaves the words unchanged. An accepted preload lands exactly on the words. A full-width unlocked write copies the write data. The control dword never returns stray bits. The done flag never falls.

Other behaviour can only be shown by the bench's scenarios. These are the reset values, partial byte-enable merges, the lock bit being cleared and then set again, preload strobes ignored after done, and the no-EEPROM strap case, which needs a fresh reset.

// File: rtl/subsys_id_pkg.sv
package subsys_id_pkg;
  parameter int unsigned ADDR_W     = 6;
  parameter int unsigned WORD_W     = 16;
  parameter int unsigned DATA_W     = 2 * WORD_W;
  parameter int unsigned BE_W       = DATA_W / 8;
  parameter int unsigned WORD_BYTES = WORD_W / 8;
  parameter logic [ADDR_W-1:0] ID_DWORD   = 6'h10;
  parameter logic [ADDR_W-1:0] CTRL_DWORD = 6'h20;
  parameter int unsigned LOCK_BIT   = 5;

  typedef struct packed {
    logic [WORD_W-1:0] device;
    logic [WORD_W-1:0] vendor;
  } id_pair_t;
endpackage

// File: rtl/subsys_id_word.sv
module subsys_id_word
  import subsys_id_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [WORD_BYTES-1:0] wr_be_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  input  logic                  load_en_i,
  input  logic [WORD_W-1:0]     load_data_i,
  output logic [WORD_W-1:0]     q_o
);
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    byte_q <= '0;
      else if (load_en_i)             byte_q <= load_data_i[8*b +: 8];
      else if (wr_en_i && wr_be_i[b]) byte_q <= wr_data_i[8*b +: 8];
    end
    assign q_o[8*b +: 8] = byte_q;
  end
endmodule

// File: rtl/subsys_lock_reg.sv
module subsys_lock_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic lock_o
);
  // comes out of reset locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_o <= 1'b1;
    else if (wr_en_i) lock_o <= wr_val_i;
  end
endmodule

// File: rtl/subsys_preload_ctl.sv
module subsys_preload_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eeprom_en_i,
  input  logic pre_valid_i,
  input  logic pre_done_i,
  output logic load_en_o,
  output logic done_o
);
  logic done_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        done_q <= 1'b0;
    else if (eeprom_en_i && pre_done_i) done_q <= 1'b1;
  end
  assign done_o    = done_q | ~eeprom_en_i;
  assign load_en_o = pre_valid_i & ~done_o;
endmodule

// File: rtl/subsys_id_regs.sv
module subsys_id_regs
  import subsys_id_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eeprom_en_i,
  input  logic              cfg_req_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [BE_W-1:0]   cfg_be_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              cfg_retry_o,
  input  logic              pre_valid_i,
  input  logic [WORD_W-1:0] pre_vendor_i,
  input  logic [WORD_W-1:0] pre_device_i,
  input  logic              pre_done_i,
  output logic              pre_done_o
);
  logic     done, load_en, lock_q;
  logic     wr_ok, id_wr, ctrl_wr;
  id_pair_t id_q;

  subsys_preload_ctl u_pre (
    .clk_i, .rst_ni, .eeprom_en_i, .pre_valid_i, .pre_done_i,
    .load_en_o(load_en), .done_o(done)
  );

  assign wr_ok       = cfg_req_i & cfg_we_i & done;
  assign cfg_retry_o = cfg_req_i & cfg_we_i & ~done;
  assign id_wr       = wr_ok & (cfg_addr_i == ID_DWORD) & ~lock_q;
  assign ctrl_wr     = wr_ok & (cfg_addr_i == CTRL_DWORD) & cfg_be_i[LOCK_BIT/8];

  subsys_lock_reg u_lock (
    .clk_i, .rst_ni, .wr_en_i(ctrl_wr), .wr_val_i(cfg_wdata_i[LOCK_BIT]),
    .lock_o(lock_q)
  );

  subsys_id_word u_vendor (
    .clk_i, .rst_ni,
    .wr_en_i(id_wr), .wr_be_i(cfg_be_i[WORD_BYTES-1:0]),
    .wr_data_i(cfg_wdata_i[WORD_W-1:0]),
    .load_en_i(load_en), .load_data_i(pre_vendor_i),
    .q_o(id_q.vendor)
  );

  subsys_id_word u_device (
    .clk_i, .rst_ni,
    .wr_en_i(id_wr), .wr_be_i(cfg_be_i[BE_W-1:WORD_BYTES]),
    .wr_data_i(cfg_wdata_i[DATA_W-1:WORD_W]),
    .load_en_i(load_en), .load_data_i(pre_device_i),
    .q_o(id_q.device)
  );

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_req_i && !cfg_we_i) begin
      if (cfg_addr_i == ID_DWORD)        cfg_rdata_o = id_q;
      else if (cfg_addr_i == CTRL_DWORD) cfg_rdata_o[LOCK_BIT] = lock_q;
    end
  end

  assign pre_done_o = done;
endmodule

// File: rtl/subsys_id_regs_chk.sv
module subsys_id_regs_chk
  import subsys_id_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_req_i,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [BE_W-1:0]   cfg_be_i,
  input logic [DATA_W-1:0] cfg_wdata_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic              cfg_retry_o,
  input logic              pre_valid_i,
  input logic [WORD_W-1:0] pre_vendor_i,
  input logic [WORD_W-1:0] pre_device_i,
  input logic              pre_done_o,
  input logic              lock_q,
  input id_pair_t          id_q
);
  // R4
  locked_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_we_i && cfg_addr_i == ID_DWORD && lock_q && !pre_valid_i)
      |=> $stable(id_q));

  // R7
  retry_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_retry_o && !pre_valid_i) |=> ($stable(id_q) && $stable(lock_q)));

  // R6
  preload_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_valid_i && !pre_done_o)
      |=> (id_q == {$past(pre_device_i), $past(pre_vendor_i)}));

  // R3
  full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_we_i && !cfg_retry_o && cfg_addr_i == ID_DWORD
     && !lock_q && cfg_be_i == '1 && !pre_valid_i)
      |=> (id_q == $past(cfg_wdata_i)));

  // R2
  ctrl_read_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && !cfg_we_i && cfg_addr_i == CTRL_DWORD)
      |-> ($countones(cfg_rdata_o) <= 1 && cfg_rdata_o[LOCK_BIT] == lock_q));

  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(pre_done_o));
endmodule

bind subsys_id_regs subsys_id_regs_chk i_chk (
  .clk_i, .rst_ni, .cfg_req_i, .cfg_we_i, .cfg_addr_i, .cfg_be_i,
  .cfg_wdata_i, .cfg_rdata_o, .cfg_retry_o, .pre_valid_i, .pre_vendor_i,
  .pre_device_i, .pre_done_o, .lock_q, .id_q
);

// File: tb/test_subsys_id_regs.sv
module test_subsys_id_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eeprom_en = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        retry;
  logic        pv = 1'b0, pd = 1'b0;
  logic [15:0] pven = '0, pdev = '0;
  logic        done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  subsys_id_regs i_subsys_id_regs (
    .clk_i(clk), .rst_ni(rst_n), .eeprom_en_i(eeprom_en),
    .cfg_req_i(req), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .cfg_retry_o(retry),
    .pre_valid_i(pv), .pre_vendor_i(pven), .pre_device_i(pdev),
    .pre_done_i(pd), .pre_done_o(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit en);
    @(negedge clk);
    rst_n = 1'b0; eeprom_en = en; req = 0; pv = 0; pd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] b,
                    input logic [31:0] d, output logic r);
    @(negedge clk);
    req = 1; we = 1; addr = a; be = b; wdata = d; #1 r = retry;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic preload(input logic [15:0] v, input logic [15:0] dv);
    @(negedge clk);
    pv = 1; pven = v; pdev = dv;
    @(negedge clk); pv = 0;
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    do_reset(1'b1);
    rd(6'h10, d); check(d == 32'h0, "R1 id reset", d, 32'h0);
    rd(6'h20, d); check(d == 32'h20, "R1 lock reset", d, 32'h20);
    check(done == 1'b0, "R1 not done", {31'b0, done}, 32'h0);
  endtask

  task automatic t_retry_and_preload;
    logic [31:0] d; logic r;
    wr(6'h20, 4'hf, 32'h0, r); check(r == 1'b1, "R7 retry ctrl", {31'b0, r}, 1);
    wr(6'h10, 4'hf, 32'hdead_beef, r); check(r == 1'b1, "R7 retry id", {31'b0, r}, 1);
    rd(6'h10, d); check(d == 32'h0, "R7 no change id", d, 32'h0);
    rd(6'h20, d); check(d == 32'h20, "R7 no change lock", d, 32'h20);
    preload(16'h104c, 16'hac56);
    rd(6'h10, d); check(d == 32'hac56_104c, "R6 preload while locked", d, 32'hac56_104c);
    @(negedge clk); pd = 1; @(negedge clk); pd = 0;
    check(done == 1'b1, "R8 done set", {31'b0, done}, 1);
    preload(16'h1111, 16'h2222);
    rd(6'h10, d); check(d == 32'hac56_104c, "R8 late preload ignored", d, 32'hac56_104c);
    check(done == 1'b1, "R8 done sticky", {31'b0, done}, 1);
  endtask

  task automatic t_lock_and_bytes;
    logic [31:0] d; logic r;
    wr(6'h10, 4'hf, 32'h1234_5678, r);
    check(r == 1'b0, "R4 no retry after done", {31'b0, r}, 0);
    rd(6'h10, d); check(d == 32'hac56_104c, "R4 locked write ignored", d, 32'hac56_104c);
    wr(6'h20, 4'he, 32'h0, r);
    rd(6'h20, d); check(d == 32'h20, "R5 lock needs be0", d, 32'h20);
    wr(6'h20, 4'h1, 32'hffff_ffdf, r);
    rd(6'h20, d); check(d == 32'h0, "R5 unlock", d, 32'h0);
    wr(6'h10, 4'hf, 32'h1234_5678, r);
    rd(6'h10, d); check(d == 32'h1234_5678, "R3 full write", d, 32'h1234_5678);
    wr(6'h10, 4'b0101, 32'haabb_ccdd, r);
    rd(6'h10, d); check(d == 32'h12bb_56dd, "R3 byte enables", d, 32'h12bb_56dd);
    wr(6'h10, 4'b0000, 32'h0, r);
    rd(6'h10, d); check(d == 32'h12bb_56dd, "R3 no enables", d, 32'h12bb_56dd);
    wr(6'h20, 4'h1, 32'h0000_0020, r);
    rd(6'h20, d); check(d == 32'h20, "R5 relock", d, 32'h20);
    wr(6'h10, 4'hf, 32'h0, r);
    rd(6'h10, d); check(d == 32'h12bb_56dd, "R4 relocked ignored", d, 32'h12bb_56dd);
    rd(6'h11, d); check(d == 32'h0, "R2 other dword zero", d, 32'h0);
  endtask

  task automatic t_no_eeprom;
    logic [31:0] d; logic r;
    do_reset(1'b0);
    rd(6'h10, d); check(d == 32'h0, "R9 reset clears words", d, 32'h0);
    check(done == 1'b1, "R9 done at reset", {31'b0, done}, 1);
    preload(16'h5555, 16'h6666);
    rd(6'h10, d); check(d == 32'h0, "R9 preload ignored", d, 32'h0);
    wr(6'h20, 4'h1, 32'h0, r); check(r == 1'b0, "R9 no retry", {31'b0, r}, 0);
    wr(6'h10, 4'b1100, 32'hbeef_0000, r);
    rd(6'h10, d); check(d == 32'hbeef_0000, "R2 word halves", d, 32'hbeef_0000);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_retry_and_preload();
        t_lock_and_bytes();
        t_no_eeprom();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule